// File: doc/BRIEF.md
# Configurable SPI Master Serial Engine

This block is the serial core of an SPI master. It accepts one word at a time from a transmit holding interface. It shifts the word out on a serial clock and data-out line, and it collects the data-in line into a receive word that it presents for one cycle. Word length runs from 2 to 32 bits. Clock polarity, clock phase, bit order, internal loopback and the line level between words are all selectable. A 16-bit reload value divides the module clock down to the bit rate.

Settings are loaded through a configuration strobe. They take effect only while the engine is in configuration mode (enable clear) and idle. Once the enable is set, words start whenever transmit data is offered. A receive-only request input starts a word instead when the transmitter is switched off. The busy output stays high until the final half period of the last bit has elapsed.

Top module: `spi_shift_core`

## Requirements
- R1: After reset the engine is in configuration mode with busy, rx_valid and tx_ready low and sclk and mosi low. Its settings are 8-bit words, polarity 0, phase bit 1, idle level 0, MSB first, loopback off, transmitter and receiver on, and reload 0.
- R2: Each serial clock half period lasts reload+1 module clock cycles, so busy is high for exactly 2·N·(reload+1) cycles per N-bit word.
- R3: cfg_width_m1 holds the word length minus one. Exactly N bits are sent and received per word, and transmit bits above bit N-1 are never sent.
- R4: With cfg_phase set, the first bit is on mosi before the first sclk edge, and data is sampled on leading edges. With cfg_phase clear, mosi changes on leading edges and data is sampled on trailing edges.
- R5: Between words sclk rests at cfg_cpol and mosi rests at cfg_idle.
- R6: cfg_msb_first set sends and assembles bit N-1 first. Clear sends and assembles bit 0 first. Received words are right-aligned in rx_data.
- R7: With cfg_loopback set, the receive path takes the block's own mosi and ignores miso.
- R8: With cfg_tx_off set, tx_valid is never accepted (tx_ready stays low). A pulse on rx_req starts a word, and mosi holds cfg_idle throughout it.
- R9: With cfg_rx_off set, no rx_valid pulse is produced, and rx_req does not start a word while cfg_tx_off is also set.
- R10: A word starts only while enabled and idle. tx_ready is the one-cycle acceptance strobe, and busy is high in the following cycle.
- R11: Configuration writes made while enabled or busy are ignored.
- R12: Every word started with the receiver on yields exactly one single-cycle rx_valid pulse. The pulse appears in the cycle after the edge on which the last bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_width_m1 | input | 5 | Word length minus one |
| cfg_cpol | input | 1 | Serial clock idle polarity |
| cfg_phase | input | 1 | 1: sample on leading edge, 0: sample on trailing edge |
| cfg_idle | input | 1 | mosi level between words |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_loopback | input | 1 | Internal mosi-to-receive loop |
| cfg_tx_off | input | 1 | Transmitter switched off |
| cfg_rx_off | input | 1 | Receiver switched off |
| cfg_reload | input | 16 | Bit-rate reload value |
| en_we | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written by en_we |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word, right-aligned |
| tx_ready | output | 1 | Transmit word accepted this cycle |
| rx_req | input | 1 | Start a receive-only word |
| rx_valid | output | 1 | Received word valid (one cycle) |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is in the shift register |

## Verification
The main path is driven through all four clock polarity and phase combinations. These runs cover both bit orders, word lengths of 2, 5, 8, 16 and 32 and several reload values. A bench-side slave model captures mosi and drives miso on the edges its own mode dictates, so a swapped edge or a reversed order shows up as a wrong word in one direction. Transmit words carry set bits above the word length, and the slave data is chosen unlike the transmit data. Together these separate masking faults and loopback faults from correct behaviour. Measured busy lengths for distinct reload and width pairs separate divider errors from bit-count errors.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;
  localparam int SPI_DW  = 32;
  localparam int SPI_BRW = 16;
  localparam int SPI_WW  = $clog2(SPI_DW);
  localparam int SPI_EW  = SPI_WW + 1;

  typedef struct packed {
    logic [SPI_WW-1:0]  width_m1;
    logic               cpol;
    logic               phase;
    logic               idle;
    logic               msb_first;
    logic               loopback;
    logic               tx_off;
    logic               rx_off;
    logic [SPI_BRW-1:0] reload;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_RST = '{width_m1: SPI_WW'(7), cpol: 1'b0, phase: 1'b1,
                                   idle: 1'b0, msb_first: 1'b1, loopback: 1'b0,
                                   tx_off: 1'b0, rx_off: 1'b0, reload: '0};
endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_core_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  spi_cfg_t cfg_in,
  input  logic     en_we,
  input  logic     en_val,
  input  logic     busy,
  output spi_cfg_t cfg,
  output logic     active
);
  spi_cfg_t cfg_n;
  logic     active_n;
  logic     cfg_load;

  assign cfg_load = cfg_we && !active && !busy;

  always_comb begin
    cfg_n    = cfg;
    active_n = active;
    if (cfg_load) cfg_n = cfg_in;
    if (en_we)    active_n = en_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RST;
      active <= 1'b0;
    end else begin
      cfg    <= cfg_n;
      active <= active_n;
    end
  end

  // R11
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active || busy) |=> $stable(cfg));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_core_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SPI_BRW-1:0] reload,
  output logic               tick
);
  logic [SPI_BRW-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    if (!run || cnt_q == '0) cnt_n = reload;
    else                     cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> !tick);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPI_WW-1:0] width_m1,
  input  logic              cpol,
  input  logic              phase,
  input  logic              idle,
  input  logic              msb_first,
  input  logic              loopback,
  input  logic              tx_off,
  input  logic              rx_off,
  input  logic              active,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic [SPI_DW-1:0] tx_data,
  input  logic              rx_req,
  input  logic              miso,
  output logic              tx_ready,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_valid,
  output logic [SPI_DW-1:0] rx_data
);
  logic              busy_n, tog_q, tog_n, mosi_q, mosi_n, rxv_n;
  logic [SPI_EW-1:0] edge_q, edge_n, last_edge, last_samp;
  logic [SPI_DW-1:0] txsr_q, txsr_n, rxsr_q, rxsr_n, rxd_n, aligned;
  logic [SPI_WW-1:0] pad;
  logic              start, leading, samp_edge, in_bit;

  assign pad       = SPI_WW'(SPI_DW - 1) - width_m1;
  assign aligned   = msb_first ? (tx_data << pad) : tx_data;
  assign last_edge = {width_m1, 1'b1};
  assign last_samp = phase ? last_edge - 1'b1 : last_edge;
  assign leading   = !edge_q[0];
  assign samp_edge = (leading == phase);
  assign in_bit    = loopback ? mosi_q : miso;

  assign start    = active && !busy && (tx_off ? (rx_req && !rx_off) : tx_valid);
  assign tx_ready = start && !tx_off;
  assign sclk     = cpol ^ tog_q;
  assign mosi     = busy ? mosi_q : idle;

  function automatic logic pick(input logic [SPI_DW-1:0] sr, input logic msb);
    return msb ? sr[SPI_DW-1] : sr[0];
  endfunction

  function automatic logic [SPI_DW-1:0] adv(input logic [SPI_DW-1:0] sr, input logic msb);
    return msb ? (sr << 1) : (sr >> 1);
  endfunction

  always_comb begin
    busy_n = busy;
    edge_n = edge_q;
    tog_n  = tog_q;
    mosi_n = mosi_q;
    txsr_n = txsr_q;
    rxsr_n = rxsr_q;
    rxd_n  = rx_data;
    rxv_n  = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      edge_n = '0;
      tog_n  = 1'b0;
      rxsr_n = '0;
      txsr_n = aligned;
      mosi_n = idle;
      if (phase && !tx_off) begin
        mosi_n = pick(aligned, msb_first);
        txsr_n = adv(aligned, msb_first);
      end
    end else if (busy && tick) begin
      tog_n  = !tog_q;
      edge_n = edge_q + 1'b1;
      if (samp_edge) begin
        rxsr_n = msb_first ? {rxsr_q[SPI_DW-2:0], in_bit} : {in_bit, rxsr_q[SPI_DW-1:1]};
        if (edge_q == last_samp && !rx_off) begin
          rxv_n = 1'b1;
          rxd_n = msb_first ? (rxsr_n & ({SPI_DW{1'b1}} >> pad)) : (rxsr_n >> pad);
        end
      end else if (edge_q != last_edge && !tx_off) begin
        mosi_n = pick(txsr_q, msb_first);
        txsr_n = adv(txsr_q, msb_first);
      end
      if (edge_q == last_edge) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_q   <= '0;
      tog_q    <= 1'b0;
      mosi_q   <= 1'b0;
      txsr_q   <= '0;
      rxsr_q   <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      busy     <= busy_n;
      edge_q   <= edge_n;
      tog_q    <= tog_n;
      mosi_q   <= mosi_n;
      txsr_q   <= txsr_n;
      rxsr_q   <= rxsr_n;
      rx_data  <= rxd_n;
      rx_valid <= rxv_n;
    end
  end

  // R5
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> busy);
  // R12
  rxv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_off);
  // R8
  tx_off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_off) |-> (mosi == idle));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_core_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SPI_WW-1:0]  cfg_width_m1,
  input  logic               cfg_cpol,
  input  logic               cfg_phase,
  input  logic               cfg_idle,
  input  logic               cfg_msb_first,
  input  logic               cfg_loopback,
  input  logic               cfg_tx_off,
  input  logic               cfg_rx_off,
  input  logic [SPI_BRW-1:0] cfg_reload,
  input  logic               en_we,
  input  logic               en_val,
  input  logic               tx_valid,
  input  logic [SPI_DW-1:0]  tx_data,
  output logic               tx_ready,
  input  logic               rx_req,
  output logic               rx_valid,
  output logic [SPI_DW-1:0]  rx_data,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               busy
);
  spi_cfg_t cfg_in, cfg;
  logic     active, tick;

  assign cfg_in = '{width_m1: cfg_width_m1, cpol: cfg_cpol, phase: cfg_phase,
                    idle: cfg_idle, msb_first: cfg_msb_first, loopback: cfg_loopback,
                    tx_off: cfg_tx_off, rx_off: cfg_rx_off, reload: cfg_reload};

  spi_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
    .en_we(en_we), .en_val(en_val), .busy(busy), .cfg(cfg), .active(active)
  );

  spi_baud_gen u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .reload(cfg.reload), .tick(tick)
  );

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .width_m1(cfg.width_m1), .cpol(cfg.cpol),
    .phase(cfg.phase), .idle(cfg.idle), .msb_first(cfg.msb_first),
    .loopback(cfg.loopback), .tx_off(cfg.tx_off), .rx_off(cfg.rx_off),
    .active(active), .tick(tick), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_req(rx_req), .miso(miso), .tx_ready(tx_ready), .busy(busy),
    .sclk(sclk), .mosi(mosi), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: tb/spi_shift_core_bench.sv
module spi_shift_core_bench;
  import spi_core_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0, en_we = 0, en_val = 0, tx_valid = 0, rx_req = 0, miso = 0;
  logic [4:0]  c_w = 7;
  logic        c_cpol = 0, c_phase = 1, c_idle = 0, c_msb = 1, c_loop = 0, c_txoff = 0, c_rxoff = 0;
  logic [15:0] c_rel = 0;
  logic [31:0] tx_data = 0;
  logic        tx_ready, rx_valid, sclk, mosi, busy;
  logic [31:0] rx_data;

  spi_shift_core u_spi_shift_core (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_width_m1(c_w), .cfg_cpol(c_cpol),
    .cfg_phase(c_phase), .cfg_idle(c_idle), .cfg_msb_first(c_msb), .cfg_loopback(c_loop),
    .cfg_tx_off(c_txoff), .cfg_rx_off(c_rxoff), .cfg_reload(c_rel), .en_we(en_we),
    .en_val(en_val), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_req(rx_req), .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  int total = 0, failed = 0, cycles = 0;

  // the settings the bench believes are loaded
  logic [4:0] k_w = 7;
  logic       k_phase = 1, k_msb = 1;

  logic [31:0] g_mosi, g_rx;
  int          g_rxv, g_busy, g_trdy;
  logic        keep_tv = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failed++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  function automatic int pos(input int j);
    return k_msb ? (int'(k_w) - j) : j;
  endfunction

  function automatic logic [31:0] mask_of(input logic [4:0] w);
    return 32'hFFFF_FFFF >> (5'd31 - w);
  endfunction

  task automatic set_en(input logic v);
    @(negedge clk); en_we = 1; en_val = v;
    @(negedge clk); en_we = 0;
  endtask

  task automatic write_cfg(input logic [4:0] w, input logic cpol, input logic ph, input logic idl,
                           input logic msb, input logic lp, input logic txo, input logic rxo,
                           input logic [15:0] rel);
    @(negedge clk);
    c_w = w; c_cpol = cpol; c_phase = ph; c_idle = idl; c_msb = msb; c_loop = lp;
    c_txoff = txo; c_rxoff = rxo; c_rel = rel; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load_cfg(input logic [4:0] w, input logic cpol, input logic ph, input logic idl,
                          input logic msb, input logic lp, input logic txo, input logic rxo,
                          input logic [15:0] rel);
    set_en(0);
    write_cfg(w, cpol, ph, idl, msb, lp, txo, rxo, rel);
    k_w = w; k_phase = ph; k_msb = msb;
    set_en(1);
  endtask

  task automatic run_word(input bit use_req, input logic [31:0] txw, input logic [31:0] slv);
    int j = 0, e = 0, guard = 0;
    bit seen = 0;
    logic prev;
    g_mosi = 0; g_rx = 0; g_rxv = 0; g_busy = 0;
    @(negedge clk);
    miso = slv[pos(0)];
    if (use_req) rx_req = 1;
    else begin tx_valid = 1; tx_data = txw; end
    prev = sclk;
    #1 g_trdy = int'(tx_ready);
    forever begin
      @(negedge clk);
      rx_req = 0; tx_valid = keep_tv;
      if (busy) begin g_busy++; seen = 1; end
      if (sclk != prev) begin
        e++; prev = sclk;
        if (((e % 2) == 1) == k_phase) begin
          if (j <= int'(k_w)) g_mosi[pos(j)] = mosi;
          j++;
          if (j <= int'(k_w)) miso = slv[pos(j)];
        end
      end
      if (rx_valid) begin g_rxv++; g_rx = rx_data; end
      guard++;
      if ((seen && !busy) || guard > 3000) break;
    end
    @(negedge clk);
    if (rx_valid) g_rxv++;
  endtask

  typedef struct packed {
    logic [4:0]  w;
    logic        cpol;
    logic        ph;
    logic        msb;
    logic [15:0] rel;
    logic [31:0] tx;
    logic [31:0] slv;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{w: 5'd7,  cpol: 1'b0, ph: 1'b1, msb: 1'b1, rel: 16'd0, tx: 32'h0000_01A5, slv: 32'h0000_003C},
    '{w: 5'd7,  cpol: 1'b1, ph: 1'b0, msb: 1'b1, rel: 16'd1, tx: 32'h0000_005A, slv: 32'h0000_00C3},
    '{w: 5'd15, cpol: 1'b0, ph: 1'b0, msb: 1'b0, rel: 16'd2, tx: 32'hFFFF_1234, slv: 32'h0000_BEEF},
    '{w: 5'd31, cpol: 1'b1, ph: 1'b1, msb: 1'b0, rel: 16'd0, tx: 32'hDEAD_BEEF, slv: 32'h0F1E_2D3C},
    '{w: 5'd1,  cpol: 1'b0, ph: 1'b1, msb: 1'b1, rel: 16'd3, tx: 32'h0000_0006, slv: 32'h0000_0001},
    '{w: 5'd31, cpol: 1'b0, ph: 1'b0, msb: 1'b1, rel: 16'd1, tx: 32'h8000_0001, slv: 32'hFFFF_0000},
    '{w: 5'd4,  cpol: 1'b1, ph: 1'b1, msb: 1'b1, rel: 16'd0, tx: 32'h0000_00F3, slv: 32'h0000_000A}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && rx_valid == 0, "R1 busy/rx_valid at reset", {busy, rx_valid}, 0);
    check(sclk == 0 && mosi == 0, "R1 sclk/mosi at reset", {sclk, mosi}, 0);
    tx_valid = 1; tx_data = 32'h55;
    #1 check(tx_ready == 0, "R10 no accept in config mode", tx_ready, 0);
    @(negedge clk); #1 check(busy == 0, "R10 no start in config mode", busy, 0);
    tx_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 idle after release", busy, 0);
    // R1 default settings: 8 bits, sample on leading edge, MSB first, reload 0
    set_en(1);
    run_word(0, 32'h96, 32'h69);
    check(g_trdy == 1, "R10 accept strobe", g_trdy, 1);
    check(g_mosi == 32'h96, "R1 default mosi word", g_mosi, 32'h96);
    check(g_rx == 32'h69, "R1 default rx word", g_rx, 32'h69);
    check(g_busy == 16, "R1 R2 default busy length", g_busy, 16);

    // main table
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [31:0] m = mask_of(v.w);
      int exp_busy = 2 * (int'(v.w) + 1) * (int'(v.rel) + 1);
      load_cfg(v.w, v.cpol, v.ph, 1'b0, v.msb, 1'b0, 1'b0, 1'b0, v.rel);
      check(sclk == v.cpol, "R5 sclk rest level", sclk, v.cpol);
      run_word(0, v.tx, v.slv);
      check(g_mosi == (v.tx & m), "R3 R4 R6 mosi word", g_mosi, v.tx & m);
      check(g_rx == (v.slv & m), "R3 R4 R6 rx word", g_rx, v.slv & m);
      check(g_busy == exp_busy, "R2 busy length", g_busy, exp_busy);
      check(g_rxv == 1, "R12 one rx_valid per word", g_rxv, 1);
      check(sclk == v.cpol, "R5 sclk rest after word", sclk, v.cpol);
    end

    // R7 loopback ignores miso
    load_cfg(5'd11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1);
    run_word(0, 32'hA3C, 32'h5C3);
    check(g_rx == 32'hA3C, "R7 loopback rx", g_rx, 32'hA3C);

    // R5 idle level and R8 transmitter off
    load_cfg(5'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0);
    check(mosi == 1 && sclk == 1, "R5 idle mosi and sclk high", {mosi, sclk}, 2'b11);
    keep_tv = 1; tx_valid = 1;
    #1 check(tx_ready == 0, "R8 tx_valid refused", tx_ready, 0);
    repeat (4) @(negedge clk);
    check(busy == 0, "R8 no word from tx_valid", busy, 0);
    run_word(1, 32'h00, 32'hB4);
    check(g_mosi == 32'hFF, "R8 mosi held idle", g_mosi, 32'hFF);
    check(g_rx == 32'hB4, "R8 receive-only word", g_rx, 32'hB4);
    check(g_trdy == 0, "R8 tx_ready low", g_trdy, 0);
    keep_tv = 0; tx_valid = 0;

    // R9 receiver off
    load_cfg(5'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd0);
    run_word(0, 32'hC7, 32'h18);
    check(g_rxv == 0, "R9 no rx_valid", g_rxv, 0);
    check(g_mosi == 32'hC7, "R9 transmit unaffected", g_mosi, 32'hC7);
    load_cfg(5'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd0);
    @(negedge clk); rx_req = 1;
    @(negedge clk); rx_req = 0;
    check(busy == 0, "R9 rx_req refused with both off", busy, 0);

    // R11 writes while enabled are ignored
    load_cfg(5'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0);
    write_cfg(5'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0);
    run_word(0, 32'h81, 32'h42);
    check(g_busy == 16, "R11 width kept while enabled", g_busy, 16);
    check(g_mosi == 32'h81, "R11 word unchanged", g_mosi, 32'h81);
    load_cfg(5'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0);
    run_word(0, 32'h8001, 32'h4002);
    check(g_busy == 32, "R11 width taken in config mode", g_busy, 32);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule